// File: doc/BRIEF.md
# Paged Test Program Memory Sequencer

This block runs one register-upset test cycle for a 32-bit processor under test and then repeats it. It owns the program store the processor fetches from. The store is split into pages of 256 32-bit words. An external pattern source picks the page. Only the word index inside a page is decoded, so the chosen page repeats across the whole 32-bit address space. Because of this, the reset fetch near the top of memory and the interrupt vector fetch near address zero are both served from one page.

The sequencer moves through a fixed cycle:

1. It holds the processor in reset.
2. It lets the processor run its load code until the processor reports that it has halted.
3. It swaps in a page made only of halt opcodes and keeps it there for a dwell of 80 percent of the test cycle. A processor that wakes up by mistake halts again at once.
4. It restores the selected page and pulses the non-maskable interrupt.
5. It opens a check window so the downstream classifier can sample the readout.
6. It starts over from reset.

If the halt acknowledge never arrives, the cycle is marked stuck and the readout is skipped.

Top module: `paged_test_seq`

## Requirements
- R1: While rst_n is low, cpu_reset_o is 1 and cpu_nmi_o, check_win_o and stuck_o are 0.
- R2: Outside the dwell, cpu_data_o is {1'b0, page_sel_i, 8'hE5, 8'h00, idx}, where idx = cpu_addr_i[9:2]. Address bits 31:10 and 1:0 have no effect, so a page repeats across the whole address space.
- R3: Outside the dwell, word index 2 (byte address 08h in any 1 KB block) returns 00000100h for every page.
- R4: cpu_reset_o is held for RST_LEN (default 4) cycles at the start of every test cycle. It then drops and the run phase begins.
- R5: When shutdown_ack_i is 1 at a clock edge in the run phase, the dwell starts on the next cycle. During the dwell every fetch returns F4F4F4F4h, whatever the address.
- R6: The dwell lasts exactly DWELL_LEN = CYCLE_LEN*8/10 cycles (160 by default). Elaboration rejects parameter sets in which the other phases do not fit in the remaining 20 percent.
- R7: After the dwell, the selected page is restored and cpu_nmi_o is 1 for NMI_LEN (default 2) cycles.
- R8: check_win_o is 1 for READ_LEN (default 8) cycles, directly after the interrupt pulse, and at no other time.
- R9: When the check window closes, a new reset phase begins.
- R10: If no acknowledge arrives within TMO_LEN (default 20) run cycles, stuck_o pulses for one cycle, together with the first cycle of a new reset. Dwell, interrupt and check window are all skipped.
- R11: shutdown_ack_i has no effect outside the run phase.
- R12: Changes of page_sel_i during the dwell do not reach cpu_data_o. After the dwell, cpu_data_o follows page_sel_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_sel_i | input | 7 | Page number from the pattern source |
| cpu_addr_i | input | 32 | Processor byte address |
| cpu_data_o | output | 32 | Fetched word (combinational) |
| cpu_reset_o | output | 1 | Reset to the processor |
| cpu_nmi_o | output | 1 | Non-maskable interrupt to the processor |
| shutdown_ack_i | input | 1 | Processor reports its halted state |
| check_win_o | output | 1 | Readout sampling window for the classifier |
| stuck_o | output | 1 | One-cycle pulse when the halt acknowledge timed out |

## Verification
A wrong phase register or a wrong counter shows up at the ports in the same cycle as the error:
- a reset, interrupt or window edge that starts one cycle early or late;
- a halt word where a page word is expected, or the reverse.

A wrong page or index decode shows up in the very fetch it affects, because cpu_data_o is combinational. A dwell of the wrong length is seen at the next interrupt edge. A missing timeout is seen after TMO_LEN run cycles, as a stuck pulse that never comes.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
   typedef enum logic [2:0] {
      PH_RST   = 3'd0,
      PH_RUN   = 3'd1,
      PH_DWELL = 3'd2,
      PH_WAKE  = 3'd3,
      PH_READ  = 3'd4
   } phase_e;
endpackage

// File: rtl/tpm_store.sv
module tpm_store #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 8,
   parameter int PAGE_W    = 7,
   parameter int VEC_IDX   = 2,
   parameter logic [31:0] VEC_WORD = 32'h0000_0100,
   parameter logic [7:0] FILL_BYTE = 8'hF4,
   parameter logic [7:0] TAG_BYTE  = 8'hE5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAGE_W-1:0] page,
   input  logic              halt_ovr,
   output logic [DATA_W-1:0] data
);
   localparam int BYTES = DATA_W / 8;
   localparam int OFS_W = $clog2(BYTES);

   initial begin
      assert (DATA_W == 32 && IDX_W == 8) else $error("store word layout needs 32-bit words, 8-bit index");
      assert (PAGE_W <= 8) else $error("page number must fit one byte");
      assert (OFS_W + IDX_W <= ADDR_W) else $error("address too narrow");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] halt_word;
   logic [DATA_W-1:0] page_word;
   logic              unused_addr_bits;

   assign idx = addr[OFS_W +: IDX_W];
   // only the in-page index is decoded: every page wraps over the space
   assign unused_addr_bits = ^{addr[ADDR_W-1:OFS_W+IDX_W], addr[OFS_W-1:0]};

   for (genvar b = 0; b < BYTES; b++) begin : g_fill
      assign halt_word[b*8 +: 8] = FILL_BYTE;
   end

   always_comb begin
      if (idx == IDX_W'(VEC_IDX))
         page_word = VEC_WORD;
      else
         page_word = {{(8-PAGE_W){1'b0}}, page, TAG_BYTE, 8'h00, idx};
   end

   assign data = halt_ovr ? halt_word : page_word;

   // R3: vector slot always answers the handler address outside the dwell
   assert_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_ovr && addr[OFS_W +: IDX_W] == IDX_W'(VEC_IDX)) |-> data == VEC_WORD);
endmodule

// File: rtl/tpm_timer.sv
module tpm_timer #(
   parameter int CNT_W = 8,
   parameter int MAX   = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   // R6: no phase can run past the longest programmed length
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAX));
endmodule

// File: rtl/tpm_fsm.sv
module tpm_fsm
   import tpm_pkg::*;
#(
   parameter int CYCLE_LEN = 200,
   parameter int RST_LEN   = 4,
   parameter int TMO_LEN   = 20,
   parameter int NMI_LEN   = 2,
   parameter int READ_LEN  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic cpu_reset,
   output logic halt_ovr,
   output logic nmi,
   output logic check_win,
   output logic stuck
);
   localparam int DWELL_LEN = CYCLE_LEN * 8 / 10;
   localparam int REST_LEN  = RST_LEN + TMO_LEN + NMI_LEN + READ_LEN;
   localparam int CNT_W     = $clog2(CYCLE_LEN + 1);

   initial begin
      assert (REST_LEN <= CYCLE_LEN - DWELL_LEN) else $error("phases exceed the 20 percent budget");
      assert (RST_LEN > 0 && TMO_LEN > 0 && NMI_LEN > 0 && READ_LEN > 0) else $error("zero phase length");
   end

   phase_e           ph, ph_nxt;
   logic [CNT_W-1:0] cnt;
   logic             clr, tmo, stuck_q;

   tpm_timer #(.CNT_W(CNT_W), .MAX(DWELL_LEN)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt)
   );

   always_comb begin
      ph_nxt = ph;
      clr    = 1'b0;
      tmo    = 1'b0;
      unique case (ph)
         PH_RST:   if (cnt == CNT_W'(RST_LEN - 1)) begin ph_nxt = PH_RUN; clr = 1'b1; end
         PH_RUN:   if (ack) begin
                      ph_nxt = PH_DWELL; clr = 1'b1;
                   end else if (cnt == CNT_W'(TMO_LEN - 1)) begin
                      ph_nxt = PH_RST; clr = 1'b1; tmo = 1'b1;
                   end
         PH_DWELL: if (cnt == CNT_W'(DWELL_LEN - 1)) begin ph_nxt = PH_WAKE; clr = 1'b1; end
         PH_WAKE:  if (cnt == CNT_W'(NMI_LEN - 1)) begin ph_nxt = PH_READ; clr = 1'b1; end
         PH_READ:  if (cnt == CNT_W'(READ_LEN - 1)) begin ph_nxt = PH_RST; clr = 1'b1; end
         default:  begin ph_nxt = PH_RST; clr = 1'b1; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_RST;
         stuck_q <= 1'b0;
      end else begin
         ph      <= ph_nxt;
         stuck_q <= tmo;
      end
   end

   assign cpu_reset = (ph == PH_RST);
   assign halt_ovr  = (ph == PH_DWELL);
   assign nmi       = (ph == PH_WAKE);
   assign check_win = (ph == PH_READ);
   assign stuck     = stuck_q;

   assert_ack_to_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RUN && ack) |=> halt_ovr);
   assert_win_after_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(check_win) |-> $past(nmi));
   assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_reset, halt_ovr, nmi, check_win}));
   assert_win_to_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(check_win) |-> cpu_reset);
   assert_stuck_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stuck |-> (cpu_reset && !$past(check_win)));
endmodule

// File: rtl/paged_test_seq.sv
module paged_test_seq #(
   parameter int CYCLE_LEN = 200,
   parameter int RST_LEN   = 4,
   parameter int TMO_LEN   = 20,
   parameter int NMI_LEN   = 2,
   parameter int READ_LEN  = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [6:0]  page_sel_i,
   input  logic [31:0] cpu_addr_i,
   output logic [31:0] cpu_data_o,
   output logic        cpu_reset_o,
   output logic        cpu_nmi_o,
   input  logic        shutdown_ack_i,
   output logic        check_win_o,
   output logic        stuck_o
);
   logic halt_ovr;

   tpm_fsm #(
      .CYCLE_LEN(CYCLE_LEN), .RST_LEN(RST_LEN), .TMO_LEN(TMO_LEN),
      .NMI_LEN(NMI_LEN), .READ_LEN(READ_LEN)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .ack(shutdown_ack_i),
      .cpu_reset(cpu_reset_o), .halt_ovr(halt_ovr), .nmi(cpu_nmi_o),
      .check_win(check_win_o), .stuck(stuck_o)
   );

   tpm_store #(
      .ADDR_W(32), .DATA_W(32), .IDX_W(8), .PAGE_W(7)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr_i), .page(page_sel_i),
      .halt_ovr(halt_ovr), .data(cpu_data_o)
   );
endmodule

// File: tb/tb_paged_test_seq.sv
module tb_paged_test_seq;
   localparam int CYC = 200, RSTL = 4, TMO = 20, NMIL = 2, RDL = 8;
   localparam int DWL = CYC * 8 / 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  page_sel_i = '0;
   logic [31:0] cpu_addr_i = '0;
   logic [31:0] cpu_data_o;
   logic        cpu_reset_o, cpu_nmi_o, check_win_o, stuck_o;
   logic        shutdown_ack_i = 1'b0;

   int checks = 0, fails = 0;
   int m_ph = 0, m_cnt = 0;
   bit m_stuck = 0;
   int f4_run = 0;
   bit prev_nmi = 0;
   logic [31:0] lfsr = 32'hACE1_2357;

   always #5 clk = ~clk;

   paged_test_seq dut (
      .clk(clk), .rst_n(rst_n), .page_sel_i(page_sel_i), .cpu_addr_i(cpu_addr_i),
      .cpu_data_o(cpu_data_o), .cpu_reset_o(cpu_reset_o), .cpu_nmi_o(cpu_nmi_o),
      .shutdown_ack_i(shutdown_ack_i), .check_win_o(check_win_o), .stuck_o(stuck_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_data(logic [31:0] a, logic [6:0] p, bit h);
      logic [7:0] idx = a[9:2];
      if (h) return 32'hF4F4_F4F4;
      if (idx == 8'd2) return 32'h0000_0100;
      return {1'b0, p, 8'hE5, 8'h00, idx};
   endfunction

   // behavioural reference: phases 0 reset,1 run,2 dwell,3 wake,4 read
   task automatic model_step(bit a);
      m_stuck = 0;
      case (m_ph)
         0: begin m_cnt++; if (m_cnt == RSTL) begin m_ph = 1; m_cnt = 0; end end
         1: if (a) begin m_ph = 2; m_cnt = 0; end
            else begin
               m_cnt++;
               if (m_cnt == TMO) begin m_ph = 0; m_cnt = 0; m_stuck = 1; end
            end
         2: begin m_cnt++; if (m_cnt == DWL) begin m_ph = 3; m_cnt = 0; end end
         3: begin m_cnt++; if (m_cnt == NMIL) begin m_ph = 4; m_cnt = 0; end end
         default: begin m_cnt++; if (m_cnt == RDL) begin m_ph = 0; m_cnt = 0; end end
      endcase
   endtask

   task automatic compare();
      chk("R4 reset", 32'(cpu_reset_o), 32'(m_ph == 0));
      chk("R7 nmi", 32'(cpu_nmi_o), 32'(m_ph == 3));
      chk("R8 window", 32'(check_win_o), 32'(m_ph == 4));
      chk("R10 stuck", 32'(stuck_o), 32'(m_stuck));
      // R2/R3/R5 data; R11 and R12 hold when ack or page changes leave it intact
      chk(m_ph == 2 ? "R5 halt page" : "R2/R3 page word", cpu_data_o,
          exp_data(cpu_addr_i, page_sel_i, m_ph == 2));
      if (cpu_data_o == 32'hF4F4_F4F4) f4_run++;
      if (cpu_nmi_o && !prev_nmi) begin
         chk("R6 dwell length", 32'(f4_run), 32'(DWL));
         f4_run = 0;
      end
      if (!check_win_o && m_ph == 0 && m_cnt == 0 && prev_nmi == 0 && !m_stuck && cpu_reset_o)
         ; // R9 loop back to reset is covered by the reset compare above
      prev_nmi = cpu_nmi_o;
   endtask

   initial begin : watchdog
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      bit ack;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset out", 32'(cpu_reset_o), 32'd1);
      chk("R1 nmi", 32'(cpu_nmi_o), 32'd0);
      chk("R1 window", 32'(check_win_o), 32'd0);
      chk("R1 stuck", 32'(stuck_o), 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 1300; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (i % 5 == 0)      cpu_addr_i = (lfsr & 32'hFFFF_FC00) | 32'h8;
         else if (i % 5 == 1) cpu_addr_i = 32'hFFFF_FFF0;
         else                 cpu_addr_i = lfsr;
         if (i % 37 == 0) page_sel_i = lfsr[12:6];  // R12 page moves mid-dwell
         if (i < 700)       ack = (m_ph == 1 && m_cnt == 5);
         else if (i < 800)  ack = 0;               // R10 timeouts
         else               ack = lfsr[3] | (m_ph != 1); // R11 ack held outside run
         shutdown_ack_i = ack;
         @(posedge clk);
         model_step(ack);
         @(negedge clk);
         compare();
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule